// File: doc/BRIEF.md
# Vertical Scan and Black-Frame Controller

This block drives the row side of a 1024-line matrix display. A line strobe from the horizontal timing generator tells it that one horizontal period has gone by. On each strobe it moves to the next gate line and toggles the vertical shift clock. It raises the vertical start pulse around the first line of every frame. It also flips the video drive polarity flag, so that the column drivers can invert the video on every line.

The block supports three active areas on the same glass: full height (5:4), 960 rows (4:3) and 720 rows (16:9). In the two reduced modes it drives equal black bands above and below the picture, so the centre of the image stays in the same place on the panel. The black-frame output goes low on the blanked rows. A row-active flag marks the rows that carry picture. Two static mode levels tell the panel which area is selected. The mode select is captured only when a frame begins. The scan direction is applied on every line and sets the phase of the vertical clock against the start pulse.

Top module: `vscan_ctrl`

## Requirements
- R1: While rst_ni is low the outputs are vstart_o=0, vclk_o=0, blank_o=1, row_active_o=0, vb_o=2'b11 and pol_o=0. The line counter is parked on the last line, so the first strobe after reset begins a frame at line 0.
- R2: A frame is LINES (1024) strobes long. vstart_o is high for lines 0 and 1 of each frame and low for all other lines.
- R3: vclk_o toggles once per line. With dir_down_i=1 it is low on even line indices and high on odd ones, so it rises in the middle of the start pulse. With dir_down_i=0 it is high on even lines and low on odd ones, so it falls in the middle of the start pulse. Line indices count from 0.
- R4: All outputs are registered. They take the values of the new line in the cycle after the clock edge that samples line_stb_i high, and they hold steady in every other cycle.
- R5: mode_i=0 (5:4) and the reserved code mode_i=3 select full height. blank_o stays high, every line is active, and vb_o=2'b11.
- R6: mode_i=1 (4:3) blanks lines 0..31 and 992..1023. On those lines blank_o=0 and row_active_o=0. On all other lines both are 1. vb_o=2'b01.
- R7: mode_i=2 (16:9) blanks lines 0..151 and 872..1023 in the same way. vb_o=2'b00.
- R8: mode_i is sampled only on the strobe that begins a frame. A change at any other time has no effect until the next frame begins.
- R9: pol_o equals the frame phase XOR bit 0 of the line index. The frame phase is 0 in the first frame after reset and inverts at every frame start, so the same line alternates polarity from frame to frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_stb_i | input | 1 | One-cycle pulse per horizontal period |
| dir_down_i | input | 1 | Scan direction: 1 downward, 0 upward |
| mode_i | input | 2 | Active area: 0 5:4, 1 4:3, 2 16:9, 3 treated as 5:4 |
| vstart_o | output | 1 | Vertical start pulse |
| vclk_o | output | 1 | Vertical shift clock |
| blank_o | output | 1 | Black-frame pulse, low on blanked rows |
| vb_o | output | 2 | Active-area mode levels |
| pol_o | output | 1 | Video polarity flag for line inversion |
| row_active_o | output | 1 | Current row carries picture |

## Verification
The bench checks the band edges in both reduced modes (lines 31/32, 991/992, 151/152 and 871/872). An off-by-one band compare would shift the picture by a row and break the centring. It changes mode_i in the middle of a frame. A design that samples the mode live would switch the band edges at that point. It reverses dir_down_i between frames and also within a frame. A design that ties the vclk_o phase to a free-running toggle, rather than to the line index and direction, would put its edge outside the start pulse. It runs several frame boundaries and checks that pol_o repeats across each boundary and that each line flips its polarity from one frame to the next.

// File: rtl/vscan_pkg.sv
package vscan_pkg;
  typedef enum logic [1:0] {
    VS_FULL = 2'd0,
    VS_STD  = 2'd1,
    VS_WIDE = 2'd2,
    VS_RSVD = 2'd3
  } vs_mode_e;

  function automatic vs_mode_e vs_clean(input logic [1:0] m);
    vs_clean = (m == 2'd3) ? VS_FULL : vs_mode_e'(m);
  endfunction
endpackage

// File: rtl/vscan_line_seq.sv
module vscan_line_seq
  import vscan_pkg::*;
#(
  parameter int LINES = 1024,
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stb_i,
  input  logic [1:0]    mode_i,
  output logic [LW-1:0] line_d_o,
  output logic          wrap_d_o,
  output vs_mode_e      mode_d_o
);
  logic [LW-1:0] line_q;
  vs_mode_e      mode_q;

  assign wrap_d_o = (line_q == LW'(LINES - 1));
  assign line_d_o = wrap_d_o ? '0 : line_q + 1'b1;
  assign mode_d_o = wrap_d_o ? vs_clean(mode_i) : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= LW'(LINES - 1);
      mode_q <= VS_FULL;
    end else if (stb_i) begin
      line_q <= line_d_o;
      mode_q <= mode_d_o;
    end
  end
endmodule

// File: rtl/vscan_band_dec.sv
module vscan_band_dec
  import vscan_pkg::*;
#(
  parameter int LINES     = 1024,
  parameter int BAND_STD  = 32,
  parameter int BAND_WIDE = 152,
  localparam int LW = $clog2(LINES)
) (
  input  logic [LW-1:0] line_i,
  input  vs_mode_e      mode_i,
  output logic          active_o,
  output logic          blank_o,
  output logic [1:0]    vb_o
);
  logic [LW:0] lo, hi, ln;

  assign ln = {1'b0, line_i};

  always_comb begin
    case (mode_i)
      VS_STD: begin
        lo   = (LW+1)'(BAND_STD);
        hi   = (LW+1)'(LINES - BAND_STD);
        vb_o = 2'b01;
      end
      VS_WIDE: begin
        lo   = (LW+1)'(BAND_WIDE);
        hi   = (LW+1)'(LINES - BAND_WIDE);
        vb_o = 2'b00;
      end
      default: begin
        lo   = '0;
        hi   = (LW+1)'(LINES);
        vb_o = 2'b11;
      end
    endcase
    active_o = (ln >= lo) && (ln < hi);
    blank_o  = (mode_i == VS_FULL) ? 1'b1 : active_o;
  end
endmodule

// File: rtl/vscan_out_reg.sv
module vscan_out_reg #(
  parameter int LINES     = 1024,
  parameter int VST_LINES = 2,
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stb_i,
  input  logic          dir_down_i,
  input  logic [LW-1:0] line_d_i,
  input  logic          wrap_d_i,
  input  logic          active_d_i,
  input  logic          blank_d_i,
  input  logic [1:0]    vb_d_i,
  output logic          vstart_o,
  output logic          vclk_o,
  output logic          blank_o,
  output logic [1:0]    vb_o,
  output logic          pol_o,
  output logic          active_o
);
  logic fpol_q, fpol_d;

  // frame phase flips at each frame start
  assign fpol_d = wrap_d_i ? ~fpol_q : fpol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fpol_q   <= 1'b1;
      vstart_o <= 1'b0;
      vclk_o   <= 1'b0;
      blank_o  <= 1'b1;
      vb_o     <= 2'b11;
      pol_o    <= 1'b0;
      active_o <= 1'b0;
    end else if (stb_i) begin
      fpol_q   <= fpol_d;
      vstart_o <= (line_d_i < LW'(VST_LINES));
      // edge lands mid start pulse; direction picks rising or falling
      vclk_o   <= dir_down_i ? line_d_i[0] : ~line_d_i[0];
      blank_o  <= blank_d_i;
      vb_o     <= vb_d_i;
      pol_o    <= fpol_d ^ line_d_i[0];
      active_o <= active_d_i;
    end
  end
endmodule

// File: rtl/vscan_ctrl.sv
module vscan_ctrl
  import vscan_pkg::*;
#(
  parameter int LINES     = 1024,
  parameter int BAND_STD  = 32,
  parameter int BAND_WIDE = 152,
  parameter int VST_LINES = 2,
  localparam int LW = $clog2(LINES)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_stb_i,
  input  logic       dir_down_i,
  input  logic [1:0] mode_i,
  output logic       vstart_o,
  output logic       vclk_o,
  output logic       blank_o,
  output logic [1:0] vb_o,
  output logic       pol_o,
  output logic       row_active_o
);
  logic [LW-1:0] line_d;
  logic          wrap_d;
  vs_mode_e      mode_d;
  logic          act_d, blk_d;
  logic [1:0]    vb_d;

  vscan_line_seq #(.LINES(LINES)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stb_i    (line_stb_i),
    .mode_i   (mode_i),
    .line_d_o (line_d),
    .wrap_d_o (wrap_d),
    .mode_d_o (mode_d)
  );

  vscan_band_dec #(
    .LINES(LINES), .BAND_STD(BAND_STD), .BAND_WIDE(BAND_WIDE)
  ) u_dec (
    .line_i   (line_d),
    .mode_i   (mode_d),
    .active_o (act_d),
    .blank_o  (blk_d),
    .vb_o     (vb_d)
  );

  vscan_out_reg #(.LINES(LINES), .VST_LINES(VST_LINES)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stb_i      (line_stb_i),
    .dir_down_i (dir_down_i),
    .line_d_i   (line_d),
    .wrap_d_i   (wrap_d),
    .active_d_i (act_d),
    .blank_d_i  (blk_d),
    .vb_d_i     (vb_d),
    .vstart_o   (vstart_o),
    .vclk_o     (vclk_o),
    .blank_o    (blank_o),
    .vb_o       (vb_o),
    .pol_o      (pol_o),
    .active_o   (row_active_o)
  );
endmodule

// File: rtl/vscan_ctrl_chk.sv
module vscan_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       line_stb_i,
  input logic       vstart_o,
  input logic       vclk_o,
  input logic       blank_o,
  input logic [1:0] vb_o,
  input logic       pol_o,
  input logic       row_active_o
);
  AST_HOLD_NO_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_stb_i |=> $stable({vstart_o, vclk_o, blank_o, vb_o, pol_o, row_active_o})); // R4

  AST_MODE_AT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vb_o) |-> $rose(vstart_o)); // R8

  AST_FULL_NO_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vb_o == 2'b11) |-> blank_o); // R5

  AST_BLANK_MATCHES_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vb_o != 2'b11) |-> (blank_o == row_active_o)); // R6

  AST_POL_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_stb_i |=> (pol_o != $past(pol_o)) || $rose(vstart_o)); // R9
endmodule

bind vscan_ctrl vscan_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .line_stb_i   (line_stb_i),
  .vstart_o     (vstart_o),
  .vclk_o       (vclk_o),
  .blank_o      (blank_o),
  .vb_o         (vb_o),
  .pol_o        (pol_o),
  .row_active_o (row_active_o)
);

// File: tb/tb_vscan_ctrl.sv
module tb_vscan_ctrl;
  localparam int LINES = 1024;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic line_stb_i = 1'b0;
  logic dir_down_i = 1'b1;
  logic [1:0] mode_i = 2'd0;
  logic vstart_o, vclk_o, blank_o, pol_o, row_active_o;
  logic [1:0] vb_o;

  always #4 clk = ~clk;

  vscan_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .line_stb_i(line_stb_i), .dir_down_i(dir_down_i),
    .mode_i(mode_i), .vstart_o(vstart_o), .vclk_o(vclk_o), .blank_o(blank_o),
    .vb_o(vb_o), .pol_o(pol_o), .row_active_o(row_active_o)
  );

  typedef struct packed {
    logic vst, vck, blk, act, pol;
    logic [1:0] vb;
    logic [1:0] mode;
    logic [10:0] line;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  bit   have_cur = 0;
  bit   stb_seen = 0;
  int   n_cmp = 0, n_err = 0;

  // independent model state
  int   m_line = LINES - 1;
  int   m_mode = 0;
  bit   m_fpol = 1;

  task automatic chk(input logic got, input logic exp, input string tag, input int ln);
    n_cmp++;
    if (got !== exp) begin
      n_err++;
      if (n_err < 30) $display("FAIL %s line %0d: got %b expected %b", tag, ln, got, exp);
    end
  endtask

  task automatic drive_line();
    exp_t e;
    int band;
    if (m_line == LINES - 1) begin
      m_line = 0;
      m_mode = (mode_i == 2'd3) ? 0 : int'(mode_i);  // R8 sampled at frame start
      m_fpol = ~m_fpol;
    end else m_line++;
    band = (m_mode == 1) ? 32 : (m_mode == 2) ? 152 : 0;
    e.line = 11'(m_line);
    e.mode = 2'(m_mode);
    e.vst  = (m_line < 2);                                  // R2
    e.vck  = dir_down_i ? m_line[0] : ~m_line[0];           // R3
    e.act  = (m_line >= band) && (m_line < LINES - band);   // R6 R7
    e.blk  = (m_mode == 0) ? 1'b1 : e.act;                  // R5
    e.vb   = (m_mode == 1) ? 2'b01 : (m_mode == 2) ? 2'b00 : 2'b11;
    e.pol  = m_fpol ^ m_line[0];                            // R9
    q.push_back(e);
    line_stb_i = 1'b1;
    @(negedge clk);
    line_stb_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_lines(input int n);
    for (int i = 0; i < n; i++) drive_line();
  endtask

  always @(posedge clk) stb_seen <= line_stb_i;

  // monitor: compare on every falling edge; new item after each strobe
  always @(negedge clk) begin
    if (rst_ni) begin
      if (stb_seen) begin
        if (q.size() == 0) begin
          n_cmp++; n_err++;
          $display("FAIL R4: output update with no expected item, got 1 expected 0");
        end else begin
          cur = q.pop_front();
          have_cur = 1;
        end
      end
      if (have_cur) begin
        chk(vstart_o, cur.vst, "R2 vstart", int'(cur.line));
        chk(vclk_o, cur.vck, "R3 vclk", int'(cur.line));
        chk(blank_o, cur.blk, (cur.mode == 0) ? "R5 blank" : (cur.mode == 1) ? "R6 blank" : "R7 blank", int'(cur.line));
        chk(row_active_o, cur.act, (cur.mode == 1) ? "R6 active" : (cur.mode == 2) ? "R7 active" : "R5 active", int'(cur.line));
        chk(vb_o[0], cur.vb[0], "R8 vb0", int'(cur.line));
        chk(vb_o[1], cur.vb[1], "R8 vb1", int'(cur.line));
        chk(pol_o, cur.pol, "R9 pol", int'(cur.line));
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(vstart_o, 1'b0, "R1 vstart", -1);
    chk(vclk_o, 1'b0, "R1 vclk", -1);
    chk(blank_o, 1'b1, "R1 blank", -1);
    chk(row_active_o, 1'b0, "R1 active", -1);
    chk(vb_o[0], 1'b1, "R1 vb0", -1);
    chk(vb_o[1], 1'b1, "R1 vb1", -1);
    chk(pol_o, 1'b0, "R1 pol", -1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    // frame 0: 5:4, downward
    mode_i = 2'd0; dir_down_i = 1'b1;
    run_lines(LINES);
    // frame 1: 4:3 upward, mid-frame switch to 16:9 must be ignored (R8)
    mode_i = 2'd1; dir_down_i = 1'b0;
    run_lines(500);
    mode_i = 2'd2;
    run_lines(LINES - 500);
    // frame 2: 16:9, direction flipped mid-frame (R3)
    dir_down_i = 1'b1;
    run_lines(700);
    dir_down_i = 1'b0;
    run_lines(LINES - 700);
    // frame 3: reserved code behaves as 5:4 (R5)
    mode_i = 2'd3; dir_down_i = 1'b1;
    run_lines(LINES);
    // frame 4: 4:3 again, polarity phase continues (R9)
    mode_i = 2'd1;
    run_lines(LINES);
    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      n_cmp++; n_err++;
      $display("FAIL R4: %0d items never produced, expected 0", q.size());
    end
    summary();
  end
endmodule